// File: doc/BRIEF.md
# Saturating Cross Dot-Product Accumulator

The unit takes two 32-bit source words. Each word packs two signed Q15 halfwords. It multiplies the halfwords crosswise: the upper half of A with the lower half of B, and the lower half of A with the upper half of B. Each product is a Q31 value with its own corner-case saturation. The two products are sign-extended, summed, and added into one of four independent 64-bit accumulators. The result is clamped to the Q31 range before it is written back.

Every saturation event sets a sticky overflow bit that belongs to the accumulator the operation addressed. The bits are gathered into a 4-bit flag field. The field can also be loaded from outside.

A test-access path lets any accumulator be loaded with a 64-bit value and read back combinationally. This is how a surrounding pipeline, or a bench, seeds accumulators and observes them. Operations are issued with a single-cycle valid strobe and complete one clock later, with a done pulse.

Top module: `xdot_acc`

## Requirements
- R1: On an accepted operation, the addressed accumulator is replaced by acc + P0 + P1, where P0 = 2·(A[31:16]·B[15:0]) and P1 = 2·(A[15:0]·B[31:16]). All halfwords are signed, and P0 and P1 are 32-bit values sign-extended to 64 bits.
- R2: A product whose two multiplicands are both 16'h8000 is taken as 32'h7FFF_FFFF. That operation sets the overflow bit of its accumulator even if the sum stays in range.
- R3: When the 64-bit sum has bit 63 clear and bits 62..31 not all zero, the accumulator is written with 64'h0000_0000_7FFF_FFFF and its overflow bit is set.
- R4: When the 64-bit sum has bit 63 set and bits 62..31 not all one, the accumulator is written with 64'hFFFF_FFFF_8000_0000 and its overflow bit is set.
- R5: `op_acc_i` (0..3) picks the accumulator. An operation leaves the other three accumulators unchanged.
- R6: `flags_o[k]` is the overflow bit of accumulator k. It is sticky: only reset or a flag write clears it, and a non-saturating operation never clears it.
- R7: `op_done_o` is high for exactly the one cycle after the edge that accepted `op_valid_i`, and low otherwise. At that point the read port shows the updated accumulator.
- R8: Asserting `rst_ni` low clears all accumulators, the flag field and `op_done_o`.
- R9: `acc_wr_i` loads `acc_wr_data_i` into accumulator `acc_wr_sel_i` on the next edge. `acc_rd_data_o` shows accumulator `acc_rd_sel_i` combinationally.
- R10: `flag_wr_i` replaces the flag field with `flag_wr_data_i`. A saturating operation in the same cycle still sets its own bit on top of the written value.
- R11: When an operation and a test write hit the same accumulator in one cycle, the operation result is stored. When they hit different accumulators, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation strobe |
| op_a_i | input | 32 | Source A, two Q15 halfwords |
| op_b_i | input | 32 | Source B, two Q15 halfwords |
| op_acc_i | input | 2 | Target accumulator of the operation |
| op_done_o | output | 1 | Operation completed |
| acc_wr_i | input | 1 | Test write strobe |
| acc_wr_sel_i | input | 2 | Test write target |
| acc_wr_data_i | input | 64 | Test write value |
| acc_rd_sel_i | input | 2 | Read port select |
| acc_rd_data_o | output | 64 | Selected accumulator contents |
| flag_wr_i | input | 1 | Flag field load strobe |
| flag_wr_data_i | input | 4 | Flag field load value |
| flags_o | output | 4 | Sticky overflow bits, one per accumulator |

## Verification
Two pairs of functions can collide in one cycle. The first is an operation and a test write. The bench issues both in the same cycle, once aimed at the same accumulator and once at different ones, then reads every accumulator back to confirm that the operation takes precedence and that the other write lands. The second is a flag load and a saturating operation. The bench issues a 16'h8000 × 16'h8000 operation in the same cycle as a flag load of zero. It expects the flag field to hold only the operation's bit, and expects a load of other bits to be merged with that bit.

// File: rtl/xdot_pkg.sv
package xdot_pkg;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned WORD_W = 2 * HALF_W;
  localparam int unsigned ACC_W  = 2 * WORD_W;
  localparam logic [HALF_W-1:0] Q15_NEG_ONE = {1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [ACC_W-1:0]  Q31_MAX = {{(WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
  localparam logic [ACC_W-1:0]  Q31_MIN = {{(WORD_W+1){1'b1}}, {(WORD_W-1){1'b0}}};
  typedef logic [HALF_W-1:0] half_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ACC_W-1:0]  acc_t;
endpackage

// File: rtl/xdot_q15_mul.sv
module xdot_q15_mul
  import xdot_pkg::*;
(
  input  half_t x_i,
  input  half_t y_i,
  output word_t p_o,
  output logic  sat_o
);
  logic signed [WORD_W-1:0] full;

  assign full  = $signed(x_i) * $signed(y_i);
  assign sat_o = (x_i == Q15_NEG_ONE) && (y_i == Q15_NEG_ONE);
  // -1.0 * -1.0 is the only product that does not fit Q31
  assign p_o   = sat_o ? {1'b0, {(WORD_W-1){1'b1}}} : {full[WORD_W-2:0], 1'b0};
endmodule

// File: rtl/xdot_acc_sat.sv
module xdot_acc_sat
  import xdot_pkg::*;
(
  input  acc_t  acc_i,
  input  word_t p0_i,
  input  word_t p1_i,
  output acc_t  res_o,
  output logic  sat_o
);
  acc_t               sum;
  logic [WORD_W-1:0]  upper;
  logic               pos_ovf;
  logic               neg_ovf;

  assign sum     = acc_i + {{WORD_W{p0_i[WORD_W-1]}}, p0_i}
                         + {{WORD_W{p1_i[WORD_W-1]}}, p1_i};
  assign upper   = sum[ACC_W-2:WORD_W-1];
  assign pos_ovf = !sum[ACC_W-1] && (|upper);
  assign neg_ovf = sum[ACC_W-1] && !(&upper);
  assign sat_o   = pos_ovf || neg_ovf;

  always_comb begin
    if (pos_ovf)      res_o = Q31_MAX;
    else if (neg_ovf) res_o = Q31_MIN;
    else              res_o = sum;
  end
endmodule

// File: rtl/xdot_acc_bank.sv
module xdot_acc_bank
  import xdot_pkg::*;
#(
  parameter int unsigned N_ACC = 4,
  localparam int unsigned IDX_W = $clog2(N_ACC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_sel_i,
  input  acc_t             upd_data_i,
  input  logic             tw_en_i,
  input  logic [IDX_W-1:0] tw_sel_i,
  input  acc_t             tw_data_i,
  input  logic [IDX_W-1:0] op_sel_i,
  output acc_t             op_data_o,
  input  logic [IDX_W-1:0] rd_sel_i,
  output acc_t             rd_data_o
);
  acc_t regs [N_ACC];

  for (genvar g = 0; g < N_ACC; g++) begin : g_acc
    acc_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      // operation result wins over a test write to the same entry
      else if (upd_en_i && upd_sel_i == IDX_W'(g)) q <= upd_data_i;
      else if (tw_en_i && tw_sel_i == IDX_W'(g))   q <= tw_data_i;
    end
    assign regs[g] = q;
  end

  assign op_data_o = regs[op_sel_i];
  assign rd_data_o = regs[rd_sel_i];
endmodule

// File: rtl/xdot_acc.sv
module xdot_acc
  import xdot_pkg::*;
#(
  parameter int unsigned N_ACC = 4,
  localparam int unsigned IDX_W = $clog2(N_ACC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic [31:0]      op_a_i,
  input  logic [31:0]      op_b_i,
  input  logic [IDX_W-1:0] op_acc_i,
  output logic             op_done_o,
  input  logic             acc_wr_i,
  input  logic [IDX_W-1:0] acc_wr_sel_i,
  input  logic [63:0]      acc_wr_data_i,
  input  logic [IDX_W-1:0] acc_rd_sel_i,
  output logic [63:0]      acc_rd_data_o,
  input  logic             flag_wr_i,
  input  logic [N_ACC-1:0] flag_wr_data_i,
  output logic [N_ACC-1:0] flags_o
);
  word_t            prod [2];
  logic [1:0]       prod_sat;
  acc_t             acc_cur;
  acc_t             acc_res;
  logic             acc_sat;
  logic             op_sat;
  logic [N_ACC-1:0] sat_set;
  logic [N_ACC-1:0] flags_q;
  logic             done_q;

  // g=0: A high x B low, g=1: A low x B high
  for (genvar g = 0; g < 2; g++) begin : g_mul
    xdot_q15_mul i_mul (
      .x_i  (op_a_i[HALF_W*(1-g) +: HALF_W]),
      .y_i  (op_b_i[HALF_W*g +: HALF_W]),
      .p_o  (prod[g]),
      .sat_o(prod_sat[g])
    );
  end

  xdot_acc_sat i_sat (
    .acc_i(acc_cur),
    .p0_i (prod[0]),
    .p1_i (prod[1]),
    .res_o(acc_res),
    .sat_o(acc_sat)
  );

  xdot_acc_bank #(.N_ACC(N_ACC)) i_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_en_i  (op_valid_i),
    .upd_sel_i (op_acc_i),
    .upd_data_i(acc_res),
    .tw_en_i   (acc_wr_i),
    .tw_sel_i  (acc_wr_sel_i),
    .tw_data_i (acc_wr_data_i),
    .op_sel_i  (op_acc_i),
    .op_data_o (acc_cur),
    .rd_sel_i  (acc_rd_sel_i),
    .rd_data_o (acc_rd_data_o)
  );

  assign op_sat  = op_valid_i && (acc_sat || (|prod_sat));
  assign sat_set = op_sat ? (N_ACC'(1) << op_acc_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      done_q  <= 1'b0;
    end else begin
      flags_q <= (flag_wr_i ? flag_wr_data_i : flags_q) | sat_set;
      done_q  <= op_valid_i;
    end
  end

  assign flags_o   = flags_q;
  assign op_done_o = done_q;
endmodule

// File: rtl/xdot_acc_chk.sv
module xdot_acc_chk #(
  parameter int unsigned N_ACC = 4,
  localparam int unsigned IDX_W = $clog2(N_ACC)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             op_valid_i,
  input logic [31:0]      op_a_i,
  input logic [31:0]      op_b_i,
  input logic [IDX_W-1:0] op_acc_i,
  input logic             flag_wr_i,
  input logic             op_done_o,
  input logic [N_ACC-1:0] flags_o,
  input logic [63:0]      acc_res_i
);
  AST_DONE_AFTER_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |=> op_done_o); // R7
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> !op_done_o); // R7
  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_wr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o))); // R6
  AST_FLAGS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_valid_i && !flag_wr_i) |=> $stable(flags_o)); // R6
  AST_PROD_SAT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_a_i[31:16] == 16'h8000 && op_b_i[15:0] == 16'h8000)
      |=> flags_o[$past(op_acc_i)]); // R2
  AST_RESULT_IN_Q31: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |-> (acc_res_i[63:31] == '0 || acc_res_i[63:31] == '1)); // R3
endmodule

bind xdot_acc xdot_acc_chk #(.N_ACC(N_ACC)) i_xdot_acc_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .op_valid_i(op_valid_i),
  .op_a_i    (op_a_i),
  .op_b_i    (op_b_i),
  .op_acc_i  (op_acc_i),
  .flag_wr_i (flag_wr_i),
  .op_done_o (op_done_o),
  .flags_o   (flags_o),
  .acc_res_i (acc_res)
);

// File: tb/test_xdot_acc.sv
module test_xdot_acc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [31:0] op_a_i = '0;
  logic [31:0] op_b_i = '0;
  logic [1:0]  op_acc_i = '0;
  logic        op_done_o;
  logic        acc_wr_i = 1'b0;
  logic [1:0]  acc_wr_sel_i = '0;
  logic [63:0] acc_wr_data_i = '0;
  logic [1:0]  acc_rd_sel_i = '0;
  logic [63:0] acc_rd_data_o;
  logic        flag_wr_i = 1'b0;
  logic [3:0]  flag_wr_data_i = '0;
  logic [3:0]  flags_o;

  int n_run = 0;
  int n_fail = 0;
  longint m_acc [4];
  logic [3:0] m_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  xdot_acc i_xdot_acc (
    .clk_i(clk), .rst_ni(rst_ni),
    .op_valid_i(op_valid_i), .op_a_i(op_a_i), .op_b_i(op_b_i), .op_acc_i(op_acc_i),
    .op_done_o(op_done_o),
    .acc_wr_i(acc_wr_i), .acc_wr_sel_i(acc_wr_sel_i), .acc_wr_data_i(acc_wr_data_i),
    .acc_rd_sel_i(acc_rd_sel_i), .acc_rd_data_o(acc_rd_data_o),
    .flag_wr_i(flag_wr_i), .flag_wr_data_i(flag_wr_data_i), .flags_o(flags_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic longint qmul(input logic [15:0] x, input logic [15:0] y);
    if (x == 16'h8000 && y == 16'h8000) return 64'sd2147483647;
    return longint'($signed(x)) * longint'($signed(y)) * 2;
  endfunction

  task automatic model_op(input logic [31:0] a, input logic [31:0] b, input int k);
    bit sat;
    longint s;
    sat = (a[31:16] == 16'h8000 && b[15:0] == 16'h8000) ||
          (a[15:0] == 16'h8000 && b[31:16] == 16'h8000);
    s = m_acc[k] + qmul(a[31:16], b[15:0]) + qmul(a[15:0], b[31:16]);
    if (s > 64'sd2147483647) begin s = 64'sd2147483647; sat = 1; end
    else if (s < -64'sd2147483648) begin s = -64'sd2147483648; sat = 1; end
    m_acc[k] = s;
    if (sat) m_flags[k] = 1'b1;
  endtask

  task automatic step(input bit op, input logic [31:0] a, input logic [31:0] b,
                      input logic [1:0] k, input bit fwe, input logic [3:0] fwd,
                      input bit twe, input logic [1:0] twk, input logic [63:0] twd);
    @(negedge clk);
    op_valid_i = op; op_a_i = a; op_b_i = b; op_acc_i = k;
    flag_wr_i = fwe; flag_wr_data_i = fwd;
    acc_wr_i = twe; acc_wr_sel_i = twk; acc_wr_data_i = twd;
    if (twe && !(op && twk == k)) m_acc[twk] = twd;
    if (fwe) m_flags = fwd;
    if (op) model_op(a, b, int'(k));
    @(negedge clk);
    op_valid_i = 1'b0; flag_wr_i = 1'b0; acc_wr_i = 1'b0;
  endtask

  task automatic do_op(input logic [31:0] a, input logic [31:0] b, input logic [1:0] k);
    step(1'b1, a, b, k, 1'b0, '0, 1'b0, '0, '0);
  endtask

  task automatic tw(input logic [1:0] k, input logic [63:0] d);
    step(1'b0, '0, '0, '0, 1'b0, '0, 1'b1, k, d);
  endtask

  task automatic fw(input logic [3:0] d);
    step(1'b0, '0, '0, '0, 1'b1, d, 1'b0, '0, '0);
  endtask

  task automatic chk_acc(input string req, input logic [1:0] k);
    acc_rd_sel_i = k;
    #1;
    chk(req, acc_rd_data_o, m_acc[k]);
  endtask

  task automatic chk_all(input string req);
    for (int k = 0; k < 4; k++) chk_acc(req, 2'(k));
    chk(req, 64'(flags_o), 64'(m_flags));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] hv [8];
    hv = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h4000, 16'hC000, 16'h1234};
    for (int k = 0; k < 4; k++) m_acc[k] = 0;
    m_flags = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk_all("R8");
    chk("R8", 64'(op_done_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R9: test write and read back on every accumulator
    for (int k = 0; k < 4; k++) tw(2'(k), 64'hA5A5_0000_0000_1111 + 64'(k));
    chk_all("R9");

    // R1 and R7: plain accumulation with done pulse
    tw(0, 64'd100);
    do_op(32'h0003_0005, 32'h0007_000B, 0);
    chk("R7", 64'(op_done_o), 64'd1);
    chk_acc("R1", 0);
    chk("R1", acc_rd_data_o, 64'd100 + 64'd66 + 64'd70);
    @(negedge clk);
    chk("R7", 64'(op_done_o), 64'd0);

    // R5: other accumulators untouched
    do_op(32'h1234_4321, 32'h0100_0200, 2);
    chk_all("R5");

    // R2: -1 x -1 product forces max Q31 and flags, no clamp
    fw(4'b0000);
    tw(1, 64'd0);
    do_op(32'h8000_0000, 32'h0000_8000, 1);
    chk_acc("R2", 1);
    chk("R2", acc_rd_data_o, 64'h0000_0000_7FFF_FFFF);
    chk("R2", 64'(flags_o), 64'h2);

    // R3: positive clamp
    tw(2, 64'h0000_0000_7FFF_0000);
    do_op(32'h7FFF_0000, 32'h0000_7FFF, 2);
    chk_acc("R3", 2);
    chk("R3", acc_rd_data_o, 64'h0000_0000_7FFF_FFFF);
    chk("R3", 64'(flags_o), 64'h6);

    // R4: negative clamp
    tw(3, 64'hFFFF_FFFF_8000_1000);
    do_op(32'h8000_0000, 32'h0000_7FFF, 3);
    chk_acc("R4", 3);
    chk("R4", acc_rd_data_o, 64'hFFFF_FFFF_8000_0000);
    chk("R4", 64'(flags_o), 64'hE);

    // R6: non-saturating operation keeps sticky bits
    do_op(32'h0001_0001, 32'h0001_0001, 1);
    tw(1, 64'd5);
    do_op(32'h0001_0001, 32'h0001_0001, 1);
    chk("R6", 64'(flags_o), 64'hE);
    chk_all("R6");

    // R10: flag load together with a saturating operation
    step(1'b1, 32'h0000_8000, 32'h8000_0000, 0, 1'b1, 4'b0000, 1'b0, '0, '0);
    chk("R10", 64'(flags_o), 64'h1);
    step(1'b1, 32'h0000_8000, 32'h8000_0000, 3, 1'b1, 4'b0100, 1'b0, '0, '0);
    chk("R10", 64'(flags_o), 64'hC);
    chk_all("R10");

    // R11: operation and test write in the same cycle
    tw(0, 64'd1000);
    step(1'b1, 32'h0002_0000, 32'h0000_0003, 0, 1'b0, '0, 1'b1, 0, 64'hDEAD);
    chk_acc("R11", 0);
    chk("R11", acc_rd_data_o, 64'd1012);
    step(1'b1, 32'h0002_0000, 32'h0000_0003, 0, 1'b0, '0, 1'b1, 1, 64'hBEEF);
    chk_all("R11");

    // R1..R4 sweep over halfword corner values
    for (int i = 0; i < 4096; i++) begin
      logic [1:0] k;
      k = 2'(i % 4);
      if (i % 5 == 0) tw(k, (i % 10 == 0) ? 64'd0 : 64'hFFFF_FFFF_C000_0000);
      if (i % 16 == 0) fw(4'b0000);
      do_op({hv[i % 8], hv[(i / 8) % 8]}, {hv[(i / 64) % 8], hv[(i / 512) % 8]}, k);
      chk("R7", 64'(op_done_o), 64'd1);
      chk_acc("R1", k);
      chk("R6", 64'(flags_o), 64'(m_flags));
    end
    chk_all("R5");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule